// File: doc/BRIEF.md
# Fifteen-Bit Wrapping Arithmetic and Logic Unit

This block is the purely combinational datapath that a small word-oriented processor core uses for its compare, arithmetic and bitwise instructions. The core has already turned each operand into a literal value below 0x8000. It presents a 4-bit operation code and two 16-bit operand words, and in the same cycle it receives a 16-bit result and a flag that reports a remainder taken with a zero divisor.

Every value the unit returns stays inside the 15-bit literal range. Sums and products wrap at 32768 and the inversion is a 15-bit complement, so the core can write any result straight back into a register without range checks. The remainder comes from a fixed restoring-division array. The block therefore holds no state and has no handshake. When the core sees the divide-by-zero flag, it raises an illegal-instruction halt.

Top module: `alu15_core`

## Requirements
- R1: Operation code 0 selects equality. The result is 1 when the two operand values are equal and 0 otherwise.
- R2: Operation code 1 selects greater-than. The result is 1 only when the first operand is strictly larger as an unsigned number, and 0 otherwise.
- R3: Operation code 2 returns the sum of the operands reduced modulo 32768. For example, 0x7FFF plus 1 gives 0.
- R4: Operation code 3 returns the low 15 bits of the product of the operands, which equals the product modulo 32768.
- R5: Operation code 4 returns the remainder of the first operand divided by a nonzero second operand. That remainder is always smaller than the divisor.
- R6: Operation code 4 with a zero divisor returns 0 and drives `div_zero` high. `div_zero` is low for every other combination of code and operands.
- R7: Operation code 5 returns the bitwise AND of the operands, and operation code 6 returns their bitwise OR.
- R8: Operation code 7 returns the bitwise complement of the first operand masked to 15 bits. The second operand has no effect on this result.
- R9: Operation codes 8 to 15 are unused. They return 0 and leave `div_zero` low.
- R10: Result bit 15 is always 0. Bit 15 of either operand is ignored, so each operation behaves as if that bit were clear.
- R11: The outputs depend only on the present inputs and settle within the same cycle the inputs change.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| op_sel | input | 4 | Operation code (0 eq, 1 gt, 2 add, 3 mul, 4 mod, 5 and, 6 or, 7 not, 8-15 unused) |
| opnd_a | input | 16 | First operand, the dividend for mod and the single operand for not |
| opnd_b | input | 16 | Second operand, the divisor for mod |
| result | output | 16 | Operation result, always below 0x8000 |
| div_zero | output | 1 | High when a remainder is requested with a zero divisor |

## Verification
Two functions can act in the same cycle: the remainder array and the divide-by-zero detection. Both see the same operand pair when code 4 is presented. A zero divisor makes the array produce a meaningless value, and the selection logic has to override it with 0 while raising the flag. The bench provokes this with several dividends against a zero divisor, including a divisor whose only set bit is the ignored bit 15. It also presents nonzero divisors and zero divisors under the other codes. On every clock it compares the result and the flag against a behavioural model that computes with plain integer arithmetic.

// File: rtl/alu15_pkg.sv
// Package alu15_pkg
// Shared widths and the operation code map of the 15-bit wrapping ALU.
// Assumes the operation codes are a fixed 4-bit encoding that the core's
// decoder relies on.
package alu15_pkg;

    parameter int unsigned WORD_W = 16;   // bus width of operands and result
    parameter int unsigned VAL_W  = 15;   // width of the literal value range
    parameter int unsigned SEL_W  = 4;    // width of the operation code

    typedef enum logic [SEL_W-1:0] {
        OP_EQ  = 4'd0,
        OP_GT  = 4'd1,
        OP_ADD = 4'd2,
        OP_MUL = 4'd3,
        OP_MOD = 4'd4,
        OP_AND = 4'd5,
        OP_OR  = 4'd6,
        OP_NOT = 4'd7
    } alu_op_e;

endpackage

// File: rtl/alu15_simple.sv
// Module alu15_simple
// Single-level operations on VAL_W-bit values: equality, unsigned
// greater-than, wrapping add, AND, OR and masked complement.
// Assumes the operands are already reduced to VAL_W bits. Dropping the
// carry out of the adder is what makes the sum wrap at 2**VAL_W.
module alu15_simple #(
    parameter int unsigned VAL_W = 15
) (
    input  logic [VAL_W-1:0] val_a,
    input  logic [VAL_W-1:0] val_b,
    output logic             eq_bit,
    output logic             gt_bit,
    output logic [VAL_W-1:0] sum_val,
    output logic [VAL_W-1:0] and_val,
    output logic [VAL_W-1:0] or_val,
    output logic [VAL_W-1:0] inv_val
);

    logic [VAL_W:0] sum_full;
    logic           unused_carry;

    // Comparisons: equality and strict unsigned magnitude.
    always_comb begin
        eq_bit = (val_a == val_b);
        gt_bit = (val_a > val_b);
    end

    // Wrapping addition: keep the low VAL_W bits and drop the carry.
    always_comb begin
        sum_full     = {1'b0, val_a} + {1'b0, val_b};
        sum_val      = sum_full[VAL_W-1:0];
        unused_carry = sum_full[VAL_W];
    end

    // Bitwise operations; the complement is confined to VAL_W bits.
    always_comb begin
        and_val = val_a & val_b;
        or_val  = val_a | val_b;
        inv_val = ~val_a;
    end

endmodule

// File: rtl/alu15_mul.sv
// Module alu15_mul
// Shift-and-add multiplier that keeps only the low VAL_W bits of the
// product, which equals the product modulo 2**VAL_W.
// Assumes VAL_W-bit operands. Partial products are truncated at each
// stage, because bits above VAL_W can never reach the kept result.
module alu15_mul #(
    parameter int unsigned VAL_W = 15
) (
    input  logic [VAL_W-1:0] mcand,
    input  logic [VAL_W-1:0] mplier,
    output logic [VAL_W-1:0] prod_low
);

    logic [VAL_W-1:0] acc [0:VAL_W];

    // Seed of the accumulation chain.
    assign acc[0] = '0;

    // One adder row per multiplier bit, each adding the shifted multiplicand.
    for (genvar i = 0; i < VAL_W; i++) begin : g_row
        logic [VAL_W-1:0] pp;
        assign pp         = mplier[i] ? (mcand << i) : '0;
        assign acc[i + 1] = acc[i] + pp;
    end

    // Low half of the product.
    assign prod_low = acc[VAL_W];

endmodule

// File: rtl/alu15_rem.sv
// Module alu15_rem
// Unrolled restoring division array that yields the remainder of a
// VAL_W-bit dividend by a VAL_W-bit divisor in one combinational pass.
// Assumes the caller masks the output when the divisor is zero. In that
// case the array passes the dividend bits through and its value is
// meaningless.
module alu15_rem #(
    parameter int unsigned VAL_W = 15
) (
    input  logic [VAL_W-1:0] dividend,
    input  logic [VAL_W-1:0] divisor,
    output logic [VAL_W-1:0] remainder
);

    logic [VAL_W-1:0] part [0:VAL_W];

    // The running remainder starts empty.
    assign part[0] = '0;

    // Each stage brings down one dividend bit, most significant first,
    // and subtracts the divisor when the shifted value can take it.
    for (genvar k = 0; k < VAL_W; k++) begin : g_stage
        logic [VAL_W:0] shifted;
        logic [VAL_W:0] diff;
        logic           fits;
        logic           unused_diff_top;
        assign shifted         = {part[k], dividend[VAL_W-1-k]};
        assign fits            = (shifted >= {1'b0, divisor});
        assign diff            = shifted - {1'b0, divisor};
        assign part[k + 1]     = fits ? diff[VAL_W-1:0] : shifted[VAL_W-1:0];
        assign unused_diff_top = diff[VAL_W];
    end

    // Final running remainder.
    assign remainder = part[VAL_W];

endmodule

// File: rtl/alu15_core.sv
// Module alu15_core
// Top of the 15-bit wrapping ALU. It strips bit 15 from both operands,
// runs every operation unit in parallel and selects one result by the
// operation code. A remainder with a zero divisor is forced to 0 and
// raises div_zero.
// Assumes a purely combinational use: no clock, no reset and no stored
// state. The outputs follow the inputs within the same cycle.
module alu15_core
    import alu15_pkg::*;
#(
    parameter int unsigned WORD_BITS = alu15_pkg::WORD_W,
    parameter int unsigned LIT_BITS  = alu15_pkg::VAL_W
) (
    input  logic [SEL_W-1:0]     op_sel,
    input  logic [WORD_BITS-1:0] opnd_a,
    input  logic [WORD_BITS-1:0] opnd_b,
    output logic [WORD_BITS-1:0] result,
    output logic                 div_zero
);

    localparam int unsigned PAD_W = WORD_BITS - LIT_BITS;

    logic [LIT_BITS-1:0] val_a;
    logic [LIT_BITS-1:0] val_b;
    logic [PAD_W-1:0]    unused_hi;
    logic                eq_bit;
    logic                gt_bit;
    logic [LIT_BITS-1:0] sum_val;
    logic [LIT_BITS-1:0] and_val;
    logic [LIT_BITS-1:0] or_val;
    logic [LIT_BITS-1:0] inv_val;
    logic [LIT_BITS-1:0] prod_val;
    logic [LIT_BITS-1:0] rem_val;
    logic                divisor_zero;
    logic [LIT_BITS-1:0] pick;

    // Operand reduction: only the literal bits take part in any operation.
    always_comb begin
        val_a     = opnd_a[LIT_BITS-1:0];
        val_b     = opnd_b[LIT_BITS-1:0];
        unused_hi = opnd_a[WORD_BITS-1:LIT_BITS] ^ opnd_b[WORD_BITS-1:LIT_BITS];
    end

    alu15_simple #(.VAL_W(LIT_BITS)) u_simple (
        .val_a   (val_a),
        .val_b   (val_b),
        .eq_bit  (eq_bit),
        .gt_bit  (gt_bit),
        .sum_val (sum_val),
        .and_val (and_val),
        .or_val  (or_val),
        .inv_val (inv_val)
    );

    alu15_mul #(.VAL_W(LIT_BITS)) u_mul (
        .mcand    (val_a),
        .mplier   (val_b),
        .prod_low (prod_val)
    );

    alu15_rem #(.VAL_W(LIT_BITS)) u_rem (
        .dividend  (val_a),
        .divisor   (val_b),
        .remainder (rem_val)
    );

    // Zero-divisor detection.
    assign divisor_zero = (val_b == '0);

    // Result selection by operation code; unused codes give 0.
    always_comb begin
        pick     = '0;
        div_zero = 1'b0;
        case (op_sel)
            OP_EQ:   pick = {{(LIT_BITS-1){1'b0}}, eq_bit};
            OP_GT:   pick = {{(LIT_BITS-1){1'b0}}, gt_bit};
            OP_ADD:  pick = sum_val;
            OP_MUL:  pick = prod_val;
            OP_MOD: begin
                div_zero = divisor_zero;
                pick     = divisor_zero ? '0 : rem_val;
            end
            OP_AND:  pick = and_val;
            OP_OR:   pick = or_val;
            OP_NOT:  pick = inv_val;
            default: pick = '0;
        endcase
    end

    // Zero-extend the literal value onto the word bus.
    assign result = {{PAD_W{1'b0}}, pick};

endmodule

// File: rtl/alu15_core_chk.sv
// Module alu15_core_chk
// Checker for alu15_core, attached by bind. The unit has no clock, so the
// checks are immediate assertions evaluated whenever the ports change.
// Assumes the default widths of 16-bit words and 15-bit literals.
module alu15_core_chk (
    input logic [3:0]  op_sel,
    input logic [15:0] opnd_a,
    input logic [15:0] opnd_b,
    input logic [15:0] result,
    input logic        div_zero
);

    // Port relations that hold for any settled input combination.
    always_comb begin
        p_msb_clear_r10: assert (result[15] == 1'b0)
            else $error("result bit 15 set");
        p_flag_only_mod_r6: assert (!div_zero || (op_sel == 4'd4 && opnd_b[14:0] == 15'd0))
            else $error("div_zero outside zero-divisor mod");
        p_flag_zero_result_r6: assert (!div_zero || result == 16'd0)
            else $error("nonzero result with div_zero");
        p_compare_boolean_r1: assert (!(op_sel == 4'd0 || op_sel == 4'd1) || result <= 16'd1)
            else $error("compare result not boolean");
        p_eq_self_r1: assert (!(op_sel == 4'd0 && opnd_a[14:0] == opnd_b[14:0]) || result == 16'd1)
            else $error("equal operands not reported equal");
        p_gt_irreflexive_r2: assert (!(op_sel == 4'd1 && opnd_a[14:0] == opnd_b[14:0]) || result == 16'd0)
            else $error("greater-than of equal operands");
        p_rem_below_divisor_r5: assert (!(op_sel == 4'd4 && opnd_b[14:0] != 15'd0) || result[14:0] < opnd_b[14:0])
            else $error("remainder not below divisor");
        p_unused_quiet_r9: assert (op_sel < 4'd8 || (result == 16'd0 && !div_zero))
            else $error("unused code produced output");
    end

endmodule

bind alu15_core alu15_core_chk u_chk (
    .op_sel   (op_sel),
    .opnd_a   (opnd_a),
    .opnd_b   (opnd_b),
    .result   (result),
    .div_zero (div_zero)
);

// File: tb/alu15_core_tb.sv
`timescale 1ns/1ps
module alu15_core_tb;

    typedef struct packed {
        logic [3:0]  op;
        logic [15:0] a;
        logic [15:0] b;
    } vec_t;

    logic        clk = 1'b0;
    logic [3:0]  op_sel = 4'd15;
    logic [15:0] opnd_a = '0;
    logic [15:0] opnd_b = '0;
    logic [15:0] result;
    logic        div_zero;

    int checks = 0;
    int fails  = 0;
    vec_t vq[$];

    always #2.5 clk = ~clk;

    alu15_core u_dut (
        .op_sel   (op_sel),
        .opnd_a   (opnd_a),
        .opnd_b   (opnd_b),
        .result   (result),
        .div_zero (div_zero)
    );

    // Behavioural reference built on integer arithmetic.
    function automatic void model(input vec_t v, output int res, output bit dz);
        int ea = int'(v.a) & 32767;
        int eb = int'(v.b) & 32767;
        dz = 1'b0;
        case (int'(v.op))
            0: res = (ea == eb) ? 1 : 0;
            1: res = (ea > eb) ? 1 : 0;
            2: res = (ea + eb) % 32768;
            3: res = (ea * eb) % 32768;
            4: begin
                if (eb == 0) begin res = 0; dz = 1'b1; end
                else res = ea % eb;
            end
            5: res = ea & eb;
            6: res = ea | eb;
            7: res = (~ea) & 32767;
            default: res = 0;
        endcase
    endfunction

    function automatic string tag_of(input vec_t v);
        if (v.a[15] || v.b[15]) return "R10";
        case (int'(v.op))
            0: return "R1";
            1: return "R2";
            2: return "R3";
            3: return "R4";
            4: return (v.b[14:0] == 0) ? "R6" : "R5";
            5, 6: return "R7";
            7: return "R8";
            default: return "R9";
        endcase
    endfunction

    task automatic push(input int op, input int a, input int b);
        vec_t v;
        v.op = op[3:0];
        v.a  = a[15:0];
        v.b  = b[15:0];
        vq.push_back(v);
    endtask

    // Drive after a rising edge, judge at the following falling edge (R11).
    task automatic run_one(input vec_t v);
        int  er;
        bit  edz;
        @(posedge clk);
        #0.5;
        op_sel = v.op;
        opnd_a = v.a;
        opnd_b = v.b;
        @(negedge clk);
        model(v, er, edz);
        checks++;
        if (int'(result) != er || div_zero != edz) begin
            fails++;
            $display("FAIL %s op=%0d a=%h b=%h actual res=%h dz=%0d expected res=%h dz=%0d",
                     tag_of(v), v.op, v.a, v.b, result, div_zero, er[15:0], edz);
        end
    endtask

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        fails++;
        checks++;
        $display("FAIL watchdog expired");
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin : main
        int seed = 32'h1234_5678;
        // Idle state with an unused code: output quiet (R9).
        @(negedge clk);
        checks++;
        if (result != 16'd0 || div_zero != 1'b0) begin
            fails++;
            $display("FAIL R9 idle actual res=%h dz=%0d expected res=0000 dz=0", result, div_zero);
        end
        // R1 equality
        push(0, 5, 5); push(0, 5, 6); push(0, 32767, 32767);
        // R2 unsigned strict greater-than
        push(1, 7, 3); push(1, 3, 7); push(1, 9, 9); push(1, 32767, 0);
        // R3 wrapping add
        push(2, 32767, 1); push(2, 16384, 16384); push(2, 100, 23);
        // R4 low product
        push(3, 32767, 32767); push(3, 256, 128); push(3, 3, 5);
        // R5 remainder
        push(4, 17, 5); push(4, 4, 9); push(4, 32767, 1); push(4, 32767, 32767);
        // R6 zero divisor, next to live remainders
        push(4, 0, 0); push(4, 123, 0); push(4, 32767, 0); push(4, 30, 7);
        // R7 and/or
        push(5, 16'h5A5A, 16'h0FF0); push(6, 16'h1234, 16'h4008);
        // R8 complement, second operand without effect
        push(7, 0, 0); push(7, 32767, 0); push(7, 16'h1234, 16'h7FFF);
        // R9 unused codes
        for (int c = 8; c < 16; c++) push(c, 16'h7ABC, 0);
        // R10 operand bit 15 ignored
        push(2, 16'h8005, 3); push(7, 16'h8000, 0); push(4, 20, 16'h8000);
        push(0, 16'h8001, 1); push(3, 16'hFFFF, 16'h8002);
        // mixed pseudo-random vectors across all codes
        for (int n = 0; n < 3000; n++) begin
            int a, b;
            seed ^= seed << 13; seed ^= seed >>> 17; seed ^= seed << 5;
            a = seed & 16'hFFFF;
            seed ^= seed << 13; seed ^= seed >>> 17; seed ^= seed << 5;
            b = (n % 11 == 0) ? 0 : (seed & 16'h7FFF);
            push((seed >>> 20) & 15, a & 16'h7FFF, b);
        end
        while (vq.size() > 0) run_one(vq.pop_front());
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

endmodule